// File: doc/BRIEF.md
# Absolute to Physical Address Mapper

This block turns an absolute address into a physical address for accesses made while virtual translation is switched off. It takes a 64-bit absolute address, a flag that says whether the processor runs in wide (64-bit) addressing mode, and a flag that picks the newer or the older architecture revision. It returns a 64-bit physical address, sign-extended from the implemented physical width, together with a tag naming the region the address falls in. The implemented physical width is a parameter that may not exceed 54 bits.

In narrow mode on the newer revision, the 32-bit space is split by its top two nibbles into a memory region, an I/O region and a firmware region, and each region widens the 32-bit offset in its own way. Absolute accesses always carry full read, write and execute rights. The mapping sits behind one register stage with a valid strobe, so that a new address can be presented on every clock and its result appears on the next one.

Top module: `abs_phys_mapper`

## Requirements
- R1: After reset, and until the first valid request, outValid is 0 and outPhys, outRegion and outPerm are all 0.
- R2: A request with inValid high on one rising edge gives outValid high exactly one cycle later; a cycle with inValid low gives outValid low one cycle later.
- R3: With inWide = 1 the result is address bits PHYS_BITS-1:0, with bit PHYS_BITS-1 copied into every higher bit, and outRegion is 2'b00 (memory); this holds whatever inNewRev is.
- R4: With inWide = 0 and inNewRev = 1, when address bits 31:28 are not 4'hF, outRegion is 2'b00 (memory) and the result is address bits 31:0 with zeros above.
- R5: With inWide = 0 and inNewRev = 1, when bits 31:28 are 4'hF and bits 27:24 are nonzero, outRegion is 2'b01 (I/O) and the result is address bits 31:0 sign-extended from bit 31.
- R6: With inWide = 0 and inNewRev = 1, when bits 31:24 are 8'hF0, outRegion is 2'b10 (firmware) and the result is address bits 31:0 with zeros above, after which every bit from PHYS_BITS-4 through 63 is forced to 1.
- R7: With inWide = 0 and inNewRev = 0, the result is always address bits 31:0 with zeros above and outRegion is 2'b00, for every value of bits 31:24.
- R8: In narrow mode, address bits 63:32 have no effect on outPhys or outRegion.
- R9: Every valid result carries outPerm = 3'b111 (bit 2 read, bit 1 write, bit 0 execute).
- R10: While outValid is low after a request, outPhys, outRegion and outPerm keep the values of the last valid result.
- R11: PHYS_BITS is checked at elaboration; values below 36 or above 54 stop elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe for the address on this edge |
| inAddr | input | 64 | Absolute address |
| inWide | input | 1 | 1 = wide addressing mode, 0 = narrow mode |
| inNewRev | input | 1 | 1 = newer architecture revision, 0 = older |
| outValid | output | 1 | Result valid, one cycle after the request |
| outPhys | output | 64 | Physical address, sign-extended to 64 bits |
| outRegion | output | 2 | 2'b00 memory, 2'b01 I/O, 2'b10 firmware |
| outPerm | output | 3 | Access rights: read, write, execute |

## Verification
The only state is the result register and the valid flag, so any fault in the mapping shows on outPhys or outRegion on the very cycle after the request that exercises it; a wrong classification boundary reveals itself only at the addresses straddling the nibble edges, which is why the corner addresses around 0xF0000000 and 0xF1000000 are driven in both revisions. A stuck or mis-enabled result register shows as a result that changes while outValid is low, or that carries a previous request's value, one cycle after an idle or a new request.

// File: rtl/abs_phys_pkg.sv
package abs_phys_pkg;

  typedef enum logic [1:0] {
    REGION_MEM  = 2'b00,
    REGION_IO   = 2'b01,
    REGION_FW   = 2'b10
  } region_e;

  typedef struct packed {
    logic loadResult;
    logic validNext;
  } mapStrobe_t;

  localparam logic [2:0] PERM_ALL = 3'b111;

endpackage

// File: rtl/abs_phys_ctrl.sv
module abs_phys_ctrl
  import abs_phys_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output mapStrobe_t strobe,
  output logic       outValid
);

  logic validQ;

  always_comb begin
    strobe.loadResult = inValid;
    strobe.validNext  = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= strobe.validNext;
  end

  assign outValid = validQ;

endmodule

// File: rtl/abs_region_classify.sv
module abs_region_classify
  import abs_phys_pkg::*;
(
  input  logic [7:0] topByte,
  input  logic       inWide,
  input  logic       inNewRev,
  output region_e    region
);

  logic topIsF;
  logic nextIsZero;

  always_comb begin
    topIsF     = (topByte[7:4] == 4'hF);
    nextIsZero = (topByte[3:0] == 4'h0);
    if (inWide || !inNewRev || !topIsF) region = REGION_MEM;
    else if (!nextIsZero)               region = REGION_IO;
    else                                region = REGION_FW;
  end

endmodule

// File: rtl/abs_phys_datapath.sv
module abs_phys_datapath
  import abs_phys_pkg::*;
#(
  parameter int PHYS_BITS = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  mapStrobe_t  strobe,
  input  logic [63:0] inAddr,
  input  logic        inWide,
  input  logic        inNewRev,
  output logic [63:0] outPhys,
  output logic [1:0]  outRegion,
  output logic [2:0]  outPerm
);

  localparam int          EXT_BITS = 64 - PHYS_BITS;
  localparam logic [63:0] FW_MASK  = {64{1'b1}} << (PHYS_BITS - 4);

  region_e     regionNow;
  logic [63:0] wideExt;
  logic [63:0] zeroExt;
  logic [63:0] signExt;
  logic [63:0] physNow;
  logic [63:0] physQ;
  logic [1:0]  regionQ;
  logic [2:0]  permQ;

  abs_region_classify u_classify (
    .topByte (inAddr[31:24]),
    .inWide  (inWide),
    .inNewRev(inNewRev),
    .region  (regionNow)
  );

  always_comb begin
    wideExt = {{EXT_BITS{inAddr[PHYS_BITS-1]}}, inAddr[PHYS_BITS-1:0]};
    zeroExt = {32'h0, inAddr[31:0]};
    signExt = {{32{inAddr[31]}}, inAddr[31:0]};
    if (inWide) begin
      physNow = wideExt;
    end else begin
      unique case (regionNow)
        REGION_IO: physNow = signExt;
        REGION_FW: physNow = zeroExt | FW_MASK;
        default:   physNow = zeroExt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      physQ   <= '0;
      regionQ <= 2'b00;
      permQ   <= 3'b000;
    end else if (strobe.loadResult) begin
      physQ   <= physNow;
      regionQ <= regionNow;
      permQ   <= PERM_ALL;
    end
  end

  assign outPhys   = physQ;
  assign outRegion = regionQ;
  assign outPerm   = permQ;

endmodule

// File: rtl/abs_phys_mapper.sv
module abs_phys_mapper
  import abs_phys_pkg::*;
#(
  parameter int PHYS_BITS = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [63:0] inAddr,
  input  logic        inWide,
  input  logic        inNewRev,
  output logic        outValid,
  output logic [63:0] outPhys,
  output logic [1:0]  outRegion,
  output logic [2:0]  outPerm
);

  // R11: physical width range checked during elaboration
  generate
    if (PHYS_BITS > 54 || PHYS_BITS < 36) begin : g_badWidth
      $error("abs_phys_mapper: PHYS_BITS out of range 36..54");
    end
  endgenerate

  mapStrobe_t strobe;

  abs_phys_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  abs_phys_datapath #(.PHYS_BITS(PHYS_BITS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inAddr   (inAddr),
    .inWide   (inWide),
    .inNewRev (inNewRev),
    .outPhys  (outPhys),
    .outRegion(outRegion),
    .outPerm  (outPerm)
  );

endmodule

// File: rtl/abs_phys_mapper_checker.sv
module abs_phys_mapper_checker #(
  parameter int PHYS_BITS = 40
) (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [63:0] inAddr,
  input logic        inWide,
  input logic        inNewRev,
  input logic        outValid,
  input logic [63:0] outPhys,
  input logic [1:0]  outRegion,
  input logic [2:0]  outPerm
);

  localparam int HI_BITS = 64 - (PHYS_BITS - 1);
  localparam int FW_BITS = 64 - (PHYS_BITS - 4);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_wide_sext_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inWide) |=> (outRegion == 2'b00) &&
      (outPhys[63:PHYS_BITS-1] == {HI_BITS{1'b0}} ||
       outPhys[63:PHYS_BITS-1] == {HI_BITS{1'b1}}));

  assert_old_rev_mem_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inWide && !inNewRev) |=> (outRegion == 2'b00) &&
      (outPhys[63:32] == 32'h0));

  assert_io_upper_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outRegion == 2'b01) |-> (outPhys[63:32] == 32'hFFFF_FFFF));

  assert_fw_upper_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outRegion == 2'b10) |-> (outPhys[63:PHYS_BITS-4] == {FW_BITS{1'b1}}));

  assert_no_bad_region_R6: assert property (@(posedge clk) disable iff (!rstN)
    outRegion != 2'b11);

  assert_full_perm_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outPerm == 3'b111));

  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outPhys) && $stable(outRegion) && $stable(outPerm)));

endmodule

bind abs_phys_mapper abs_phys_mapper_checker #(.PHYS_BITS(PHYS_BITS)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inAddr   (inAddr),
  .inWide   (inWide),
  .inNewRev (inNewRev),
  .outValid (outValid),
  .outPhys  (outPhys),
  .outRegion(outRegion),
  .outPerm  (outPerm)
);

// File: tb/abs_phys_mapper_bench.sv
module abs_phys_mapper_bench;

  localparam int N = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] inAddr = '0;
  logic        inWide = 1'b0;
  logic        inNewRev = 1'b1;
  logic        outValid;
  logic [63:0] outPhys;
  logic [1:0]  outRegion;
  logic [2:0]  outPerm;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  abs_phys_mapper #(.PHYS_BITS(N)) u_abs_phys_mapper (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inAddr(inAddr),
    .inWide(inWide), .inNewRev(inNewRev), .outValid(outValid),
    .outPhys(outPhys), .outRegion(outRegion), .outPerm(outPerm)
  );

  function automatic logic [1:0] refRegion(logic [63:0] a, logic w, logic nr);
    if (w || !nr) return 2'b00;
    if (a[31:28] != 4'hF) return 2'b00;
    if (a[27:24] == 4'h0) return 2'b10;
    return 2'b01;
  endfunction

  function automatic logic [63:0] refPhys(logic [63:0] a, logic w, logic nr);
    logic [63:0] r;
    logic [1:0]  g;
    r = '0;
    if (w) begin
      for (int i = 0; i < 64; i++) r[i] = (i < N) ? a[i] : a[N-1];
      return r;
    end
    g = refRegion(a, w, nr);
    for (int i = 0; i < 32; i++) r[i] = a[i];
    for (int i = 32; i < 64; i++) r[i] = (g == 2'b01) ? a[31] : 1'b0;
    if (g == 2'b10) for (int i = N - 4; i < 64; i++) r[i] = 1'b1;
    return r;
  endfunction

  task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive one request, then check the registered result one cycle later
  task automatic applyVec(string req, logic [63:0] a, logic w, logic nr);
    @(negedge clk);
    inAddr = a; inWide = w; inNewRev = nr; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check64(req, "valid", {63'h0, outValid}, 64'h1);
    check64(req, "phys", outPhys, refPhys(a, w, nr));
    check64(req, "region", {62'h0, outRegion}, {62'h0, refRegion(a, w, nr)});
    check64("R9", "perm", {61'h0, outPerm}, 64'h7);
  endtask

  task automatic testReset();
    check64("R1", "valid", {63'h0, outValid}, 64'h0);
    check64("R1", "phys", outPhys, 64'h0);
    check64("R1", "region", {62'h0, outRegion}, 64'h0);
    check64("R1", "perm", {61'h0, outPerm}, 64'h0);
  endtask

  task automatic testWide();
    applyVec("R3", 64'h0000_0080_0000_0000, 1'b1, 1'b1);
    applyVec("R3", 64'h0000_007F_FFFF_FFFF, 1'b1, 1'b1);
    applyVec("R3", 64'hABCD_00C1_2345_6789, 1'b1, 1'b0);
    applyVec("R3", 64'h1234_5600_F000_0000, 1'b1, 1'b1);
  endtask

  task automatic testNarrowCorners();
    applyVec("R4", 64'h0000_0000_EFFF_FFFF, 1'b0, 1'b1);
    applyVec("R6", 64'h0000_0000_F000_0000, 1'b0, 1'b1);
    applyVec("R6", 64'h0000_0000_F0FF_FFFF, 1'b0, 1'b1);
    applyVec("R5", 64'h0000_0000_F100_0000, 1'b0, 1'b1);
    applyVec("R5", 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b1);
    applyVec("R4", 64'h0000_0000_0000_1000, 1'b0, 1'b1);
  endtask

  task automatic testOldRev();
    applyVec("R7", 64'h0000_0000_F000_0000, 1'b0, 1'b0);
    applyVec("R7", 64'h0000_0000_F100_0000, 1'b0, 1'b0);
    applyVec("R7", 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0);
  endtask

  task automatic testUpperIgnored();
    applyVec("R8", 64'hFFFF_FFFF_1234_5678, 1'b0, 1'b1);
    applyVec("R8", 64'h8000_0001_F000_0010, 1'b0, 1'b1);
    applyVec("R8", 64'hDEAD_BEEF_F200_0000, 1'b0, 1'b1);
  endtask

  task automatic testHold();
    logic [63:0] exp;
    applyVec("R10", 64'h0000_0000_F300_0040, 1'b0, 1'b1);
    exp = refPhys(64'h0000_0000_F300_0040, 1'b0, 1'b1);
    @(negedge clk);
    inAddr = 64'h0000_0000_1111_1111; inWide = 1'b1;
    check64("R2", "valid idle", {63'h0, outValid}, 64'h0);
    check64("R10", "phys held", outPhys, exp);
    @(negedge clk);
    check64("R10", "region held", {62'h0, outRegion}, 64'h1);
    check64("R10", "perm held", {61'h0, outPerm}, 64'h7);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    inAddr = 64'h0000_0000_F000_0004; inWide = 1'b0; inNewRev = 1'b1; inValid = 1'b1;
    @(negedge clk);
    check64("R2", "first phys", outPhys, refPhys(64'h0000_0000_F000_0004, 1'b0, 1'b1));
    inAddr = 64'h0000_0000_7000_0000;
    @(negedge clk);
    inValid = 1'b0;
    check64("R2", "second valid", {63'h0, outValid}, 64'h1);
    check64("R2", "second phys", outPhys, 64'h0000_0000_7000_0000);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWide();
    testNarrowCorners();
    testOldRev();
    testUpperIgnored();
    testHold();
    testBackToBack();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule